// File: doc/BRIEF.md
# Transmit Queue to FIFO Channel Steering Arbiter

This block picks, every cycle, one transmit queue to serve and the FIFO channel its frame request goes to. Sixteen circular queues are each bound by a software-written map entry to exactly one of eight channels, and several queues may share a channel. Channel 7 carries commands and outranks everything. Channels 0 to 3 carry traffic of rising priority: background, best effort, video, then voice and management. Channels 4 to 6 are not used for traffic and are never granted.

Arbitration has two levels. Among channels whose FIFO reports room and that have at least one active, ready queue mapped to them, the highest-ranked channel wins. Within that channel a per-channel round-robin pointer picks the queue. The pointer moves past the granted queue only when the consumer accepts the grant, so an unaccepted grant is offered again unchanged. The output is combinational from the registered map, the pointers and the current request and room inputs.

Map entries are written one queue at a time through a register write port. A write takes effect on the cycle after the write edge.

Top module: `txq_steer_arb`

## Requirements
- R1: After reset every queue is inactive and mapped to channel 0, every round-robin pointer is 0, and grant_valid_o is 0 whatever q_ready_i and ch_room_i are.
- R2: When cfg_we_i is high at a clock edge, queue cfg_qidx_i takes channel cfg_data_i[2:0] and active flag cfg_data_i[3]. The grant in the cycle of the write still uses the old entry. The next cycle uses the new entry.
- R3: A queue is a candidate only while its active flag is 1 and its q_ready_i bit is 1.
- R4: Channel rank from highest to lowest is 7, 3, 2, 1, 0. The granted channel is the highest-ranked channel that has a candidate and room.
- R5: A queue mapped to channel 4, 5 or 6 is never granted.
- R6: A channel whose ch_room_i bit is 0 is skipped, and a lower-ranked channel with room and a candidate is granted instead.
- R7: Within the winning channel, the granted queue is the first candidate found scanning upward from that channel's pointer, wrapping from 15 to 0.
- R8: When a grant is accepted (grant_valid_o and grant_accept_i both high at an edge), that channel's pointer becomes the granted queue index plus 1, modulo 16. Other pointers, and all pointers on unaccepted cycles, keep their values.
- R9: grant_ch_o is the mapped channel of grant_q_o while grant_valid_o is 1. Both are 0 while grant_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Map entry write strobe |
| cfg_qidx_i | input | 4 | Queue whose entry is written |
| cfg_data_i | input | 4 | Bit 3 active flag, bits 2:0 channel |
| q_ready_i | input | 16 | Per-queue frame ready flags |
| ch_room_i | input | 8 | Per-channel FIFO has room |
| grant_accept_i | input | 1 | Consumer takes the offered grant |
| grant_valid_o | output | 1 | A grant is offered |
| grant_q_o | output | 4 | Granted queue index |
| grant_ch_o | output | 3 | Granted channel index |

## Verification
Directed patterns come first. A single queue separates write timing from grant timing. Queues on competing channels with room withdrawn one channel at a time tell the channel ranking apart from backpressure skipping. A queue parked on an unused channel shows that such channels are never served. Three queues sharing one channel, granted with and without accept, show that the rotation order comes from the pointer and moves only on accept. A long pseudo-random sweep then mixes map rewrites, ready masks, room masks and accepts, and compares every cycle against an arithmetic model of the ranking and rotation rules.

// File: rtl/txq_steer_pkg.sv
package txq_steer_pkg;
  localparam int unsigned NUM_CH     = 8;
  localparam int unsigned CH_W       = $clog2(NUM_CH);
  localparam int unsigned CMD_CH     = 7;
  localparam int unsigned TRAFFIC_CH = 4;
  localparam int unsigned CFG_W      = CH_W + 1;

  typedef struct packed {
    logic            act;
    logic [CH_W-1:0] ch;
  } q_cfg_t;
endpackage

// File: rtl/txq_map_regs.sv
module txq_map_regs
  import txq_steer_pkg::*;
#(
  parameter int unsigned NUM_Q = 16,
  localparam int unsigned QW   = $clog2(NUM_Q)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [QW-1:0]          qidx_i,
  input  logic [CFG_W-1:0]       data_i,
  output q_cfg_t [NUM_Q-1:0]     cfg_o
);
  for (genvar q = 0; q < NUM_Q; q++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_o[q] <= '0;
      end else if (we_i && (qidx_i == QW'(q))) begin
        cfg_o[q] <= q_cfg_t'(data_i);
      end
    end
  end
endmodule

// File: rtl/txq_rr_pick.sv
module txq_rr_pick #(
  parameter int unsigned N  = 16,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          adv_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] ptr_q;
  logic [IW-1:0] j;

  // scan upward from ptr_q; N is a power of two so IW-bit add wraps
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    j       = '0;
    for (int k = 0; k < N; k++) begin
      j = ptr_q + IW'(k);
      if (!valid_o && req_i[j]) begin
        valid_o = 1'b1;
        idx_o   = j;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (adv_i) ptr_q <= idx_o + IW'(1);
  end
endmodule

// File: rtl/txq_ch_select.sv
module txq_ch_select
  import txq_steer_pkg::*;
(
  input  logic [NUM_CH-1:0] has_req_i,
  input  logic [NUM_CH-1:0] room_i,
  output logic              valid_o,
  output logic [CH_W-1:0]   ch_o
);
  logic [NUM_CH-1:0] elig;
  assign elig = has_req_i & room_i;

  always_comb begin
    valid_o = 1'b0;
    ch_o    = '0;
    if (elig[CMD_CH]) begin
      valid_o = 1'b1;
      ch_o    = CH_W'(CMD_CH);
    end else begin
      for (int c = TRAFFIC_CH - 1; c >= 0; c--) begin
        if (!valid_o && elig[c]) begin
          valid_o = 1'b1;
          ch_o    = CH_W'(c);
        end
      end
    end
  end
endmodule

// File: rtl/txq_steer_arb.sv
module txq_steer_arb
  import txq_steer_pkg::*;
#(
  parameter int unsigned NUM_Q = 16,
  localparam int unsigned QW   = $clog2(NUM_Q)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [QW-1:0]     cfg_qidx_i,
  input  logic [CFG_W-1:0]  cfg_data_i,
  input  logic [NUM_Q-1:0]  q_ready_i,
  input  logic [NUM_CH-1:0] ch_room_i,
  input  logic              grant_accept_i,
  output logic              grant_valid_o,
  output logic [QW-1:0]     grant_q_o,
  output logic [CH_W-1:0]   grant_ch_o
);
  q_cfg_t [NUM_Q-1:0]           q_cfg;
  logic   [NUM_CH-1:0][NUM_Q-1:0] ch_req;
  logic   [NUM_CH-1:0]          pick_v;
  logic   [NUM_CH-1:0][QW-1:0]  pick_idx;
  logic                         sel_v;
  logic   [CH_W-1:0]            sel_ch;
  logic                         take;

  txq_map_regs #(.NUM_Q(NUM_Q)) u_map (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .qidx_i (cfg_qidx_i),
    .data_i (cfg_data_i),
    .cfg_o  (q_cfg)
  );

  assign take = sel_v & grant_accept_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
      assign ch_req[c][q] = q_ready_i[q] & q_cfg[q].act & (q_cfg[q].ch == CH_W'(c));
    end
    txq_rr_pick #(.N(NUM_Q)) u_rr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (ch_req[c]),
      .adv_i   (take && (sel_ch == CH_W'(c))),
      .valid_o (pick_v[c]),
      .idx_o   (pick_idx[c])
    );
  end

  txq_ch_select u_sel (
    .has_req_i (pick_v),
    .room_i    (ch_room_i),
    .valid_o   (sel_v),
    .ch_o      (sel_ch)
  );

  assign grant_valid_o = sel_v;
  assign grant_ch_o    = sel_v ? sel_ch : '0;
  assign grant_q_o     = sel_v ? pick_idx[sel_ch] : '0;
endmodule

// File: rtl/txq_steer_arb_chk.sv
module txq_steer_arb_chk
  import txq_steer_pkg::*;
#(
  parameter int unsigned NUM_Q = 16,
  localparam int unsigned QW   = $clog2(NUM_Q)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [NUM_Q-1:0]  q_ready_i,
  input logic [NUM_CH-1:0] ch_room_i,
  input logic              grant_accept_i,
  input logic              grant_valid_o,
  input logic [QW-1:0]     grant_q_o,
  input logic [CH_W-1:0]   grant_ch_o,
  input q_cfg_t [NUM_Q-1:0] q_cfg
);
  logic cmd_pend;
  always_comb begin
    cmd_pend = 1'b0;
    for (int q = 0; q < NUM_Q; q++)
      if (q_ready_i[q] && q_cfg[q].act && q_cfg[q].ch == CH_W'(CMD_CH)) cmd_pend = 1'b1;
    cmd_pend = cmd_pend & ch_room_i[CMD_CH];
  end

  p_ready_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> (q_ready_i[grant_q_o] && q_cfg[grant_q_o].act));

  p_cmd_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_pend |-> (grant_valid_o && grant_ch_o == CH_W'(CMD_CH)));

  p_legal_ch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> (grant_ch_o < CH_W'(TRAFFIC_CH) || grant_ch_o == CH_W'(CMD_CH)));

  p_room_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> ch_room_i[grant_ch_o]);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_valid_o && !grant_accept_i && !cfg_we_i) |=>
      (!($stable(q_ready_i) && $stable(ch_room_i)) || (grant_valid_o && $stable(grant_q_o))));

  p_map_ch_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> (q_cfg[grant_q_o].ch == grant_ch_o));

  p_idle_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grant_valid_o |-> (grant_q_o == '0 && grant_ch_o == '0));
endmodule

bind txq_steer_arb txq_steer_arb_chk #(.NUM_Q(NUM_Q)) u_chk (.*);

// File: tb/txq_steer_arb_bench.sv
`timescale 1ns/1ps
module txq_steer_arb_bench;
  localparam int NQ = 16;
  localparam int NC = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [3:0]  cfg_qidx_i = '0;
  logic [3:0]  cfg_data_i = '0;
  logic [15:0] q_ready_i = '0;
  logic [7:0]  ch_room_i = '0;
  logic        grant_accept_i = 1'b0;
  logic        grant_valid_o;
  logic [3:0]  grant_q_o;
  logic [2:0]  grant_ch_o;

  int n_chk = 0;
  int n_bad = 0;

  int m_ch  [NQ];
  bit m_act [NQ];
  int m_ptr [NC];

  always #5 clk_i = ~clk_i;

  txq_steer_arb u_txq_steer_arb (.*);

  task automatic expect_grant(output bit v, output int q, output int ch);
    int order [5] = '{7, 3, 2, 1, 0};
    v = 0; q = 0; ch = 0;
    foreach (order[i]) begin
      int c = order[i];
      if (!v && ch_room_i[c]) begin
        for (int k = 0; k < NQ; k++) begin
          int j = (m_ptr[c] + k) % NQ;
          if (!v && q_ready_i[j] && m_act[j] && m_ch[j] == c) begin
            v = 1; q = j; ch = c;
          end
        end
      end
    end
  endtask

  task automatic compare(string tag);
    bit ev; int eq; int ech;
    expect_grant(ev, eq, ech);
    n_chk++;
    if (grant_valid_o !== ev || int'(grant_q_o) != eq || int'(grant_ch_o) != ech) begin
      n_bad++;
      $display("FAIL %s: got v=%0b q=%0d ch=%0d, expected v=%0b q=%0d ch=%0d",
               tag, grant_valid_o, grant_q_o, grant_ch_o, ev, eq, ech);
    end
  endtask

  // sample mid low phase, optionally accept at the next edge
  task automatic step(string tag, bit acc);
    @(negedge clk_i); #1;
    compare(tag);
    grant_accept_i = acc;
    @(posedge clk_i);
    if (grant_valid_o && acc) m_ptr[grant_ch_o] = (int'(grant_q_o) + 1) % NQ;
    #1 grant_accept_i = 1'b0;
  endtask

  task automatic cfg(int q, bit act, int ch);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_qidx_i = 4'(q); cfg_data_i = {act, 3'(ch)};
    @(posedge clk_i);
    m_act[q] = act; m_ch[q] = ch;
    #1 cfg_we_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    foreach (m_ch[i]) begin m_ch[i] = 0; m_act[i] = 0; end
    foreach (m_ptr[i]) m_ptr[i] = 0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1: reset state, nothing active even with all ready and room
    q_ready_i = '1; ch_room_i = '1;
    step("R1", 1);
    step("R1", 0);

    // R2: write is invisible in its own cycle, visible the next
    q_ready_i = '0; q_ready_i[5] = 1'b1;
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_qidx_i = 4'd5; cfg_data_i = {1'b1, 3'd2};
    #1 compare("R2");
    @(posedge clk_i); m_act[5] = 1; m_ch[5] = 2;
    #1 cfg_we_i = 1'b0;
    step("R2", 0);

    // R3: ready low removes the candidate
    q_ready_i[5] = 1'b0;
    step("R3", 0);
    q_ready_i[5] = 1'b1;
    cfg(5, 0, 2);
    step("R3", 0);
    cfg(5, 1, 2);

    // R4: ranking 7 > 3 > 2 > 1 > 0
    cfg(1, 1, 0); cfg(9, 1, 3);
    q_ready_i = '0; q_ready_i[1] = 1; q_ready_i[5] = 1; q_ready_i[9] = 1;
    step("R4", 0);
    cfg(12, 1, 7); q_ready_i[12] = 1;
    step("R4", 0);

    // R6: backpressure skips to the next channel with room
    ch_room_i[7] = 1'b0; step("R6", 0);
    ch_room_i[3] = 1'b0; step("R6", 0);
    ch_room_i[2] = 1'b0; step("R6", 0);
    ch_room_i = '1;

    // R5: unused channels never granted
    q_ready_i = '0; q_ready_i[2] = 1; q_ready_i[3] = 1; q_ready_i[4] = 1;
    cfg(2, 1, 4); cfg(3, 1, 5); cfg(4, 1, 6);
    step("R5", 0);

    // R7/R8: rotation among queues 0, 8, 14 on channel 1
    for (int q = 0; q < NQ; q++) cfg(q, 0, 0);
    cfg(0, 1, 1); cfg(8, 1, 1); cfg(14, 1, 1);
    q_ready_i = '0; q_ready_i[0] = 1; q_ready_i[8] = 1; q_ready_i[14] = 1;
    step("R8", 0);
    step("R8", 0);
    for (int i = 0; i < 5; i++) step("R7", 1);
    q_ready_i[0] = 0;
    step("R7", 1);
    step("R7", 1);

    // sweep: random map rewrites, ready/room masks and accepts
    for (int it = 0; it < 4000; it++) begin
      if ($urandom_range(7) == 0) cfg($urandom_range(15), 1'($urandom_range(3) != 0), $urandom_range(7));
      q_ready_i = 16'($urandom);
      ch_room_i = 8'($urandom) | 8'($urandom);
      step("R7/R9", 1'($urandom_range(1)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule